// File: doc/BRIEF.md
# Length-Prefixed Transmit Packet FIFO

This block is the host-facing half of an Ethernet transmit path. Software loads one frame through 32-bit writes to a data register. The first two bytes of that stream are a length prefix and the frame bytes follow them. Software then launches the frame with a start bit. The block turns the stored words into a byte stream with a valid/ready/last handshake for the line-side MAC logic. On the way out it can zero-fill short frames to the minimum size and can append the Ethernet frame check sequence.

Completion is reported through a transmit-empty status bit. That bit drives an interrupt line through a mask and is cleared by a write-one acknowledge. The start bit reads back as a busy flag for the whole transmission, and the host waits for it to fall before it loads the next frame. Preamble, start delimiter, nibble timing and collision handling belong to the logic downstream.

Top module: `txpf_top`

## Requirements
- R1: After reset, `tx_valid`, `irq` and `full_duplex` are 0, and the busy bit (address 2, bit 0) and the status bit (address 3, bit 0) both read 0.
- R2: The host writes a frame of L bytes as (L+5)/4 words to address 1. Word bits 7:0 hold the earliest byte. The first 16 bits are L-14, low byte first, and the frame bytes follow at once.
- R3: Writing 1 to bit 0 of address 2 launches the stored frame when the transmitter is enabled (control register at address 0, bit 0). From then on, that bit reads 1 until the final output byte is accepted. A launch while the transmitter is disabled is ignored.
- R4: Data-register writes made while the busy bit is 1 are ignored and do not alter the frame being sent.
- R5: The stream carries the L frame bytes in order, taken from each word least significant byte first.
- R6: With padding enabled (control bit 2), a frame shorter than 60 bytes is followed by zero bytes up to 60 bytes.
- R7: With CRC enabled (control bit 1), the block appends the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, final inversion). It covers data and pad bytes and is sent as 4 bytes, least significant first.
- R8: `tx_last` is 1 exactly on the final byte. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold.
- R9: The status bit sets when the final byte is accepted. `irq` equals status AND mask (address 4, bit 0). Writing 1 to bit 0 of address 5 clears status, and a set in the same cycle wins.
- R10: Control bit 3 drives the `full_duplex` output.
- R11: The pad and CRC settings are captured at launch. Changing the control register during a transmission does not change the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_rd_addr | input | 3 | Host read address |
| host_rdata | output | 32 | Host read data (combinational) |
| tx_data | output | 8 | Output byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| irq | output | 1 | Masked transmit-empty interrupt |
| full_duplex | output | 1 | Duplex mode from the control register |

## Verification
A wrong byte counter or word index shows up on `tx_data` on the very byte it corrupts. The position where `tx_last` falls then moves, so the collected frame length is wrong once the frame ends. A corrupted CRC register only becomes visible in the four trailing bytes, so frames are checked as a whole against a bench-computed sequence. A stuck phase shows up as the busy bit or `tx_valid` staying high past the expected frame length. The run also checks status and `irq` in the cycle after the final byte is accepted, and a frame loaded during a disabled launch must come out intact later.

// File: rtl/txpf_pkg.sv
package txpf_pkg;

    localparam int HOST_AW = 3;

    // Host register addresses
    typedef enum logic [HOST_AW-1:0] {
        REG_CTRL   = 3'd0,
        REG_DATA   = 3'd1,
        REG_LAUNCH = 3'd2,
        REG_STAT   = 3'd3,
        REG_MASK   = 3'd4,
        REG_ACK    = 3'd5
    } host_reg_e;

    // Control word, bit 0 is tx_en
    typedef struct packed {
        logic duplex;
        logic pad_en;
        logic crc_en;
        logic tx_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_PAD,
        PH_FCS
    } phase_e;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // One byte of the reflected CRC-32 update
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/txpf_regs.sv
module txpf_regs
    import txpf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    input  logic [HOST_AW-1:0] host_rd_addr,
    output logic [31:0]        host_rdata,
    input  logic               busy,
    input  logic               frame_done,
    output ctrl_t              ctrl,
    output logic               launch,
    output logic               data_push,
    output logic               stat_raw,
    output logic               irq
);

    logic mask_q;
    logic wr_ctrl, wr_mask, wr_ack;

    always_comb begin
        wr_ctrl   = host_wr_en && (host_addr == REG_CTRL);
        wr_mask   = host_wr_en && (host_addr == REG_MASK);
        wr_ack    = host_wr_en && (host_addr == REG_ACK) && host_wdata[0];
        // A launch only takes effect on an idle, enabled transmitter
        launch    = host_wr_en && (host_addr == REG_LAUNCH) && host_wdata[0]
                    && ctrl.tx_en && !busy;
        // The frame store is frozen while a frame is on its way out
        data_push = host_wr_en && (host_addr == REG_DATA) && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            mask_q   <= 1'b0;
            stat_raw <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(host_wdata[3:0]);
            if (wr_mask) mask_q <= host_wdata[0];
            if (frame_done)  stat_raw <= 1'b1;
            else if (wr_ack) stat_raw <= 1'b0;
        end
    end

    assign irq = stat_raw & mask_q;

    always_comb begin
        host_rdata = '0;
        case (host_rd_addr)
            REG_CTRL:   host_rdata = {28'd0, ctrl};
            REG_LAUNCH: host_rdata = {31'd0, busy};
            REG_STAT:   host_rdata = {31'd0, stat_raw};
            REG_MASK:   host_rdata = {31'd0, mask_q};
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txpf_buf.sv
module txpf_buf #(
    parameter int WORDS = 380,
    parameter int IDX_W = 9,
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [31:0]      push_word,
    input  logic             clear,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word,
    output logic [15:0]      len_field
);

    logic [31:0]      mem [WORDS];
    logic [PTR_W-1:0] wr_ptr;
    logic             room;

    assign room = wr_ptr < PTR_W'(WORDS);

    // The pointer rewinds at launch, so the next load starts at word 0
    always_ff @(posedge clk) begin
        if (rst)               wr_ptr <= '0;
        else if (clear)        wr_ptr <= '0;
        else if (push && room) wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push && room) mem[IDX_W'(wr_ptr)] <= push_word;
    end

    assign rd_word   = mem[rd_idx];
    assign len_field = mem[0][15:0];

endmodule

// File: rtl/txpf_seq.sv
module txpf_seq
    import txpf_pkg::*;
#(
    parameter int MAX_FRAME = 1518,
    parameter int MIN_FRAME = 60,
    parameter int CNT_W     = 11,
    parameter int IDX_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  ctrl_t            ctrl,
    input  logic [15:0]      len_field,
    input  logic [31:0]      rd_word,
    output logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             tx_last,
    output logic             busy,
    output logic             frame_done,
    output logic             mode_pad,
    output logic             mode_crc
);

    localparam int POS_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(MAX_FRAME);
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_FRAME);
    localparam int HDR_BYTES = 14;

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] flen;
    logic [1:0]       fcs_idx;
    logic [31:0]      crc;
    logic             pad_l, crc_l;

    logic [16:0]      len_sum;
    logic [CNT_W-1:0] len_clip;
    logic [POS_W-1:0] pos;
    logic [1:0]       sel;
    logic [31:0]      fcs_word;
    logic             accept, end_data, end_pad, need_pad;

    always_comb begin
        len_sum  = {1'b0, len_field} + 17'(HDR_BYTES);
        len_clip = (len_sum > 17'(MAX_FRAME)) ? MAX_LEN : len_sum[CNT_W-1:0];
        // Buffer byte position skips the two prefix bytes
        pos      = {1'b0, cnt} + POS_W'(2);
        rd_idx   = IDX_W'(pos >> 2);
        sel      = pos[1:0];
        fcs_word = ~crc;
        end_data = (cnt == flen - 1'b1);
        end_pad  = (cnt == MIN_LEN - 1'b1);
        need_pad = pad_l && (flen < MIN_LEN);
    end

    assign busy     = (phase != PH_IDLE);
    assign tx_valid = busy;
    assign accept   = tx_valid && tx_ready;

    always_comb begin
        case (phase)
            PH_DATA: tx_data = rd_word[{sel, 3'b000} +: 8];
            PH_FCS:  tx_data = fcs_word[{fcs_idx, 3'b000} +: 8];
            default: tx_data = 8'd0;
        endcase
    end

    always_comb begin
        case (phase)
            PH_DATA: tx_last = end_data && !need_pad && !crc_l;
            PH_PAD:  tx_last = end_pad && !crc_l;
            PH_FCS:  tx_last = (fcs_idx == 2'd3);
            default: tx_last = 1'b0;
        endcase
    end

    assign frame_done = accept && tx_last;
    assign mode_pad   = pad_l;
    assign mode_crc   = crc_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            flen    <= '0;
            fcs_idx <= '0;
            crc     <= '1;
            pad_l   <= 1'b0;
            crc_l   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (launch) begin
                        phase   <= PH_DATA;
                        cnt     <= '0;
                        flen    <= len_clip;
                        fcs_idx <= '0;
                        crc     <= '1;
                        pad_l   <= ctrl.pad_en;
                        crc_l   <= ctrl.crc_en;
                    end
                end
                PH_DATA: begin
                    if (accept) begin
                        crc <= crc_step(crc, tx_data);
                        if (end_data) begin
                            if (need_pad) begin
                                phase <= PH_PAD;
                                cnt   <= cnt + 1'b1;
                            end else begin
                                phase <= crc_l ? PH_FCS : PH_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_PAD: begin
                    if (accept) begin
                        crc <= crc_step(crc, tx_data);
                        if (end_pad) phase <= crc_l ? PH_FCS : PH_IDLE;
                        else         cnt   <= cnt + 1'b1;
                    end
                end
                PH_FCS: begin
                    if (accept) begin
                        if (fcs_idx == 2'd3) phase   <= PH_IDLE;
                        else                 fcs_idx <= fcs_idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txpf_top.sv
module txpf_top
    import txpf_pkg::*;
#(
    parameter int MAX_FRAME = 1518,
    parameter int MIN_FRAME = 60
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    input  logic [HOST_AW-1:0] host_rd_addr,
    output logic [31:0]        host_rdata,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_last,
    output logic               irq,
    output logic               full_duplex
);

    localparam int WORDS = (MAX_FRAME + 5) / 4;
    localparam int IDX_W = $clog2(WORDS);
    localparam int PTR_W = $clog2(WORDS + 1);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);

    ctrl_t             ctrl;
    logic              launch, data_push, busy, frame_done, stat_raw;
    logic              mode_pad, mode_crc;
    logic [IDX_W-1:0]  rd_idx;
    logic [31:0]       rd_word;
    logic [15:0]       len_field;

    txpf_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .host_wr_en   (host_wr_en),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rd_addr (host_rd_addr),
        .host_rdata   (host_rdata),
        .busy         (busy),
        .frame_done   (frame_done),
        .ctrl         (ctrl),
        .launch       (launch),
        .data_push    (data_push),
        .stat_raw     (stat_raw),
        .irq          (irq)
    );

    txpf_buf #(
        .WORDS (WORDS),
        .IDX_W (IDX_W),
        .PTR_W (PTR_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (data_push),
        .push_word (host_wdata),
        .clear     (launch),
        .rd_idx    (rd_idx),
        .rd_word   (rd_word),
        .len_field (len_field)
    );

    txpf_seq #(
        .MAX_FRAME (MAX_FRAME),
        .MIN_FRAME (MIN_FRAME),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .ctrl       (ctrl),
        .len_field  (len_field),
        .rd_word    (rd_word),
        .rd_idx     (rd_idx),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_last    (tx_last),
        .busy       (busy),
        .frame_done (frame_done),
        .mode_pad   (mode_pad),
        .mode_crc   (mode_crc)
    );

    assign full_duplex = ctrl.duplex;

endmodule

// File: rtl/txpf_checker.sv
module txpf_checker #(
    parameter int MIN_FRAME = 60
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_last,
    input logic       busy,
    input logic       stat_raw,
    input logic       mode_pad,
    input logic       mode_crc
);

    logic [15:0] seen;
    logic        acc_last;

    assign acc_last = tx_valid && tx_ready && tx_last;

    // Bytes already accepted in the current frame
    always_ff @(posedge clk) begin
        if (rst)                        seen <= '0;
        else if (acc_last)              seen <= '0;
        else if (tx_valid && tx_ready)  seen <= seen + 1'b1;
    end

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_valid);

    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r3_busy_ends_on_last: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(acc_last));

    a_r9_stat_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_raw) |-> $past(acc_last));

    a_r6_pad_reaches_min: assert property (@(posedge clk) disable iff (rst)
        (acc_last && mode_pad && !mode_crc) |-> (seen >= 16'(MIN_FRAME - 1)));

    a_r7_fcs_after_min: assert property (@(posedge clk) disable iff (rst)
        (acc_last && mode_pad && mode_crc) |-> (seen >= 16'(MIN_FRAME + 3)));

endmodule

bind txpf_top txpf_checker #(.MIN_FRAME(MIN_FRAME)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_last  (tx_last),
    .busy     (busy),
    .stat_raw (stat_raw),
    .mode_pad (mode_pad),
    .mode_crc (mode_crc)
);

// File: tb/tb_txpf_top.sv
module tb_txpf_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [2:0]  host_rd_addr = 3'd0;
    logic [31:0] host_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        tx_last;
    logic        irq;
    logic        full_duplex;

    int checks = 0;
    int fails  = 0;

    logic [7:0] frame [0:1517];
    logic [7:0] expb  [0:1600];
    logic [7:0] gotb  [0:1600];

    always #2 clk = ~clk;

    txpf_top dut (
        .clk          (clk),
        .rst          (rst),
        .host_wr_en   (host_wr_en),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rd_addr (host_rd_addr),
        .host_rdata   (host_rdata),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_last      (tx_last),
        .irq          (irq),
        .full_duplex  (full_duplex)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd_addr = a;
        #1 d = host_rdata;
    endtask

    // Reference CRC: bit-serial, least significant bit first
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ expb[i][k];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    function automatic logic [7:0] stream_byte(input int i, input int len);
        logic [15:0] lf = 16'(len - 14);
        if (i == 0) return lf[7:0];
        if (i == 1) return lf[15:8];
        if (i < len + 2) return frame[i - 2];
        return 8'd0;
    endfunction

    task automatic load_frame(input int len);
        for (int i = 0; i < len; i++) frame[i] = 8'($urandom);
        for (int w = 0; w < (len + 5) / 4; w++) begin
            hw(3'd1, {stream_byte(4*w+3, len), stream_byte(4*w+2, len),
                      stream_byte(4*w+1, len), stream_byte(4*w, len)});
        end
    endtask

    // Launches an already loaded frame and compares the stream
    task automatic run_frame(input int len, input bit pad, input bit crc,
                             input int rdy_pct, input bit disturb);
        logic [31:0] r;
        int n, got, last_pos, bad, first_bad;
        n = len;
        for (int i = 0; i < len; i++) expb[i] = frame[i];
        if (pad && len < 60) begin
            for (int i = len; i < 60; i++) expb[i] = 8'd0;
            n = 60;
        end
        if (crc) begin
            logic [31:0] f = ref_crc(n);
            for (int k = 0; k < 4; k++) expb[n + k] = f[8*k +: 8];
            n = n + 4;
        end
        hw(3'd2, 32'd1);
        hr(3'd2, r);
        check("R3 busy after launch", r, 32'd1);
        if (disturb) begin
            hw(3'd1, 32'hDEADBEEF);
            hw(3'd1, 32'h0BADF00D);
            hw(3'd0, {28'd0, 1'b0, pad, ~crc, 1'b1});
        end
        got = 0; last_pos = -1;
        for (int cyc = 0; cyc < 8000 && last_pos < 0; cyc++) begin
            @(negedge clk);
            tx_ready = (($urandom % 100) < rdy_pct);
            if (tx_valid && tx_ready) begin
                if (got <= 1600) gotb[got] = tx_data;
                if (tx_last) last_pos = got;
                got++;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
        check("R8 last on final byte", 32'(last_pos), 32'(n - 1));
        bad = 0; first_bad = -1;
        for (int i = 0; i < n && i < got; i++) begin
            if (gotb[i] !== expb[i]) begin
                if (first_bad < 0) first_bad = i;
                bad++;
            end
        end
        if (disturb) check("R4 R11 frame intact", 32'(bad), 32'd0);
        else if (crc) check("R5 R6 R7 frame bytes", 32'(bad), 32'd0);
        else check("R5 R6 frame bytes", 32'(bad), 32'd0);
        if (first_bad >= 0)
            $display("    first mismatch at byte %0d got=%0h exp=%0h", first_bad,
                     gotb[first_bad], expb[first_bad]);
        hr(3'd2, r);
        check("R3 busy clear after frame", r, 32'd0);
        hr(3'd3, r);
        check("R9 status set after frame", r, 32'd1);
        hw(3'd5, 32'd1);
        hr(3'd3, r);
        check("R9 ack clears status", r, 32'd0);
    endtask

    task automatic full_frame(input int len, input bit pad, input bit crc,
                              input int rdy_pct, input bit disturb);
        hw(3'd0, {28'd0, 1'b0, pad, crc, 1'b1});
        load_frame(len);
        run_frame(len, pad, crc, rdy_pct, disturb);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 valid idle", 32'(tx_valid), 32'd0);
        check("R1 irq idle", 32'(irq), 32'd0);
        check("R1 duplex idle", 32'(full_duplex), 32'd0);
        hr(3'd2, r); check("R1 busy idle", r, 32'd0);
        hr(3'd3, r); check("R1 status idle", r, 32'd0);

        // Directed corner lengths, R2 packing included
        full_frame(14, 1'b1, 1'b1, 100, 1'b0);
        full_frame(59, 1'b1, 1'b1, 60, 1'b0);
        full_frame(60, 1'b1, 1'b1, 70, 1'b0);
        full_frame(61, 1'b1, 1'b0, 50, 1'b0);
        full_frame(20, 1'b0, 1'b1, 80, 1'b0);
        full_frame(21, 1'b0, 1'b0, 90, 1'b0);
        full_frame(33, 1'b1, 1'b0, 40, 1'b0);
        full_frame(1518, 1'b0, 1'b1, 90, 1'b0);

        // Random lengths and modes
        for (int t = 0; t < 10; t++) begin
            int l = 14 + int'($urandom % 190);
            full_frame(l, 1'($urandom), 1'($urandom), 30 + int'($urandom % 71), 1'b0);
        end

        // R4 and R11: data writes and a control change while busy
        full_frame(45, 1'b1, 1'b1, 75, 1'b1);
        full_frame(80, 1'b0, 1'b0, 75, 1'b1);

        // R3: launch with the transmitter disabled is ignored
        hw(3'd0, 32'h6);
        load_frame(40);
        hw(3'd2, 32'd1);
        hr(3'd2, r); check("R3 disabled launch ignored", r, 32'd0);
        begin
            int seenv = 0;
            repeat (10) begin
                @(negedge clk);
                if (tx_valid) seenv++;
            end
            check("R3 no output while disabled", 32'(seenv), 32'd0);
        end
        hw(3'd0, 32'h7);
        run_frame(40, 1'b1, 1'b1, 80, 1'b0);

        // R9 interrupt masking and acknowledge
        full_frame(25, 1'b0, 1'b1, 100, 1'b0);
        hw(3'd0, 32'h3);
        load_frame(30);
        hw(3'd2, 32'd1);
        @(negedge clk); tx_ready = 1'b1;
        while (!(tx_valid && tx_last)) @(negedge clk);
        @(negedge clk); tx_ready = 1'b0;
        check("R9 irq masked", 32'(irq), 32'd0);
        hr(3'd3, r); check("R9 raw set while masked", r, 32'd1);
        hw(3'd4, 32'd1);
        check("R9 irq follows mask", 32'(irq), 32'd1);
        hw(3'd5, 32'd1);
        check("R9 irq cleared by ack", 32'(irq), 32'd0);

        // R10 duplex output
        hw(3'd0, 32'h9);
        check("R10 duplex set", 32'(full_duplex), 32'd1);
        hw(3'd0, 32'h1);
        check("R10 duplex clear", 32'(full_duplex), 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule